// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block sits between a CPU register port and a 4096-byte nonvolatile data store. Software sees four byte-wide registers, selected by a two-bit index: the low and high halves of a 12-bit byte address, a data byte, and a control byte. A read is started by a strobe bit in the control byte. The byte at the current address lands in the data register on the next clock edge, and the CPU is held for a fixed number of cycles.

A write is guarded by an unlock sequence. Software first sets an arming bit. That bit drops by itself after a short window. Software must then set the write bit while the arming bit is still high. An accepted write stays in progress for a fixed number of cycles of a separate, slower timing clock. Its completion is carried back into the CPU clock domain, where it clears the write bit.

While a write runs, the address cannot be changed and read strobes are ignored. An external busy input, used during program-memory self-programming, blocks new writes. A level-type ready interrupt is raised whenever the store is idle and software has enabled it.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset, the control and data registers read 0x00, and both `cpu_stall` and `rdy_irq` are low.
- R2: The address is 12 bits wide. Index 0 holds address bits 7:0. Index 1 holds address bits 11:8 in its bits 3:0, and bits 7:4 of index 1 always read as zero.
- R3: The control register at index 3 has this layout: bit 3 is the interrupt enable, bit 2 is arm, bit 1 is write-in-progress, and bit 0 is the read strobe. Bits 7:4 and bit 0 always read as zero. Index 2 is the data register, which software can read and write.
- R4: Software sets arm by writing 1 to control bit 2; writing 0 there does not clear it. Arm reads as 1 in the four cycles that follow the set, and hardware clears it on the fifth cycle.
- R5: Writing control bit 1 as 1 while arm reads 1 starts a write of the data register into the address. Control bit 1 then reads 1. If arm is 0, the same write has no effect: bit 1 stays 0 and the memory is left unchanged.
- R6: While `flash_busy` is high, a write cannot start: control bit 1 stays 0 and the memory is left unchanged.
- R7: Control bit 1 stays 1 for at least `WRITE_TICKS` periods of `tmr_clk`. After that, hardware clears it through the clock-domain synchronisers; software cannot clear it.
- R8: A read strobe (control bit 0 written as 1 while idle) loads the addressed byte into the data register one cycle later. It holds `cpu_stall` high for four cycles.
- R9: An accepted write holds `cpu_stall` high for two cycles.
- R10: While a write is in progress, writes to the address registers and read strobes are ignored. The data register keeps its value and `cpu_stall` stays low.
- R11: `rdy_irq` equals `glob_ie` AND the interrupt enable AND NOT write-in-progress, as a continuous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| tmr_clk | input | 1 | Slow timing clock for the write duration |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index: 0 address low, 1 address high, 2 data, 3 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back value of the selected register |
| glob_ie | input | 1 | Global interrupt enable |
| flash_busy | input | 1 | Program-memory self-programming in progress |
| cpu_stall | output | 1 | Holds the CPU |
| rdy_irq | output | 1 | Level ready interrupt |

## Verification
The unlock window edge is the hardest case to reach from the ports. The write bit has to land exactly on the last cycle in which arm is still set, and then again one cycle later. The stimulus is driven on the falling clock edge, and a fixed number of idle cycles is counted after the arming write, so the accepted case and the rejected case each fall on a known rising edge. Both cases are then confirmed through memory read-back. The long write interval crosses two clock domains. The bench checks it from both sides: the write bit must still be set shortly before the minimum timing-clock count, and it must clear within a bounded wait afterwards.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR_LO = 2'd0,
      SEL_ADDR_HI = 2'd1,
      SEL_DATA    = 2'd2,
      SEL_CTRL    = 2'd3
   } nvm_sel_e;

   localparam int CTL_IE  = 3;
   localparam int CTL_ARM = 2;
   localparam int CTL_WE  = 1;
   localparam int CTL_RD  = 0;
endpackage

// File: rtl/nvm_sync.sv
module nvm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   initial assert (STAGES >= 2) else $error("nvm_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= 1'b0;
      else        pipe[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[i] <= 1'b0;
         else        pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
   parameter int WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic armed_o
);
   localparam int CW = $clog2(WIN + 1);
   logic [CW-1:0] left_q;

   initial assert (WIN >= 1) else $error("nvm_unlock: WIN must be positive");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (set_i)          left_q <= CW'(WIN);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign armed_o = (left_q != '0);

   // R4
   unlock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> armed_o);
endmodule

// File: rtl/nvm_stall.sv
module nvm_stall #(
   parameter int RD_CYC = 4,
   parameter int WR_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_i,
   input  logic wr_i,
   output logic stall_o
);
   localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
   localparam int SW   = $clog2(MAXC + 1);
   logic [SW-1:0] cnt_q;

   initial assert (RD_CYC >= 1 && WR_CYC >= 1) else $error("nvm_stall: counts must be positive");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (wr_i)         cnt_q <= SW'(WR_CYC);
      else if (rd_i)         cnt_q <= SW'(RD_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign stall_o = (cnt_q != '0);

   // R8
   stall_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> stall_o);
   // R9
   stall_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> stall_o);
endmodule

// File: rtl/nvm_wtimer.sv
module nvm_wtimer #(
   parameter int TICKS       = 8448,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic tmr_clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);
   localparam int TW = $clog2(TICKS + 1);

   logic          start_tgl, req_s, req_seen, go;
   logic [TW-1:0] cnt_q;
   logic          done_tgl, done_s, done_seen;

   initial assert (TICKS >= 2) else $error("nvm_wtimer: TICKS must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       start_tgl <= 1'b0;
      else if (start_i) start_tgl <= ~start_tgl;
   end

   nvm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(tmr_clk), .rst_n(rst_n), .d(start_tgl), .q(req_s));

   assign go = req_s ^ req_seen;

   always_ff @(posedge tmr_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_seen <= 1'b0;
         cnt_q    <= '0;
         done_tgl <= 1'b0;
      end else begin
         req_seen <= req_s;
         if (go) cnt_q <= TW'(TICKS);
         else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == TW'(1)) done_tgl <= ~done_tgl;
         end
      end
   end

   nvm_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done_tgl), .q(done_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_seen <= 1'b0;
      else        done_seen <= done_s;
   end

   assign done_o = done_s ^ done_seen;

   // R7
   timer_busy_chk: assert property (@(posedge tmr_clk) disable iff (!rst_n)
      (cnt_q > TW'(1)) |=> (cnt_q != '0));
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
   import nvm_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int UNLOCK_WIN  = 4,
   parameter int RD_STALL    = 4,
   parameter int WR_STALL    = 2,
   parameter int WRITE_TICKS = 8448,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tmr_clk,
   input  logic       reg_we,
   input  logic [1:0] reg_sel,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       glob_ie,
   input  logic       flash_busy,
   output logic       cpu_stall,
   output logic       rdy_irq
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HI_W  = ADDR_W - 8;
   localparam int AGE_W = $clog2(UNLOCK_WIN + 2);

   initial assert (ADDR_W >= 9 && ADDR_W <= 16) else $error("nvm_access_ctrl: ADDR_W out of range");

   nvm_sel_e         sel;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]       data_q, addr_hi_rd;
   logic [7:0]       mem [DEPTH];
   logic             ie_q, we_busy, armed, done_p;
   logic             wr_lo, wr_hi, wr_dat, wr_ctl, arm_set, wr_go, rd_go;

   assign sel     = nvm_sel_e'(reg_sel);
   assign wr_lo   = reg_we && (sel == SEL_ADDR_LO);
   assign wr_hi   = reg_we && (sel == SEL_ADDR_HI);
   assign wr_dat  = reg_we && (sel == SEL_DATA);
   assign wr_ctl  = reg_we && (sel == SEL_CTRL);
   assign arm_set = wr_ctl && reg_wdata[CTL_ARM];
   assign wr_go   = wr_ctl && reg_wdata[CTL_WE] && armed && !we_busy && !flash_busy;
   assign rd_go   = wr_ctl && reg_wdata[CTL_RD] && !we_busy && !wr_go;

   nvm_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
      .clk(clk), .rst_n(rst_n), .set_i(arm_set), .armed_o(armed));

   nvm_stall #(.RD_CYC(RD_STALL), .WR_CYC(WR_STALL)) u_stall (
      .clk(clk), .rst_n(rst_n), .rd_i(rd_go), .wr_i(wr_go), .stall_o(cpu_stall));

   nvm_wtimer #(.TICKS(WRITE_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_timer (
      .clk(clk), .tmr_clk(tmr_clk), .rst_n(rst_n), .start_i(wr_go), .done_o(done_p));

   // address has no reset: software must load it before use
   always_ff @(posedge clk) begin
      if (!we_busy) begin
         if (wr_lo) addr_q[7:0]        <= reg_wdata;
         if (wr_hi) addr_q[ADDR_W-1:8] <= reg_wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_go) mem[addr_q] <= data_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         ie_q    <= 1'b0;
         we_busy <= 1'b0;
      end else begin
         if (rd_go)       data_q <= mem[addr_q];
         else if (wr_dat) data_q <= reg_wdata;
         if (wr_ctl)      ie_q   <= reg_wdata[CTL_IE];
         if (wr_go)       we_busy <= 1'b1;
         else if (done_p) we_busy <= 1'b0;
      end
   end

   if (ADDR_W < 16) begin : g_hi_pad
      assign addr_hi_rd = {{(16 - ADDR_W){1'b0}}, addr_q[ADDR_W-1:8]};
   end else begin : g_hi_full
      assign addr_hi_rd = addr_q[15:8];
   end

   always_comb begin
      unique case (sel)
         SEL_ADDR_LO: reg_rdata = addr_q[7:0];
         SEL_ADDR_HI: reg_rdata = addr_hi_rd;
         SEL_DATA:    reg_rdata = data_q;
         default:     reg_rdata = {4'b0000, ie_q, armed, we_busy, 1'b0};
      endcase
   end

   assign rdy_irq = glob_ie && ie_q && !we_busy;

   // checker state: cycles since the last arming write
   logic [AGE_W-1:0] arm_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          arm_age <= '0;
      else if (arm_set)                    arm_age <= '0;
      else if (arm_age != AGE_W'(UNLOCK_WIN)) arm_age <= arm_age + 1'b1;
   end

   // R4
   unlock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (arm_age < AGE_W'(UNLOCK_WIN)));
   // R10
   busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_busy && (wr_lo || wr_hi)) |=> $stable(addr_q));
   // R6
   flash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_busy && !we_busy) |=> !we_busy);
   // R11
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> !rdy_irq);
endmodule

// File: tb/sim_nvm_access_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_access_ctrl;
   localparam int TICKS = 40;

   logic       clk = 1'b0, tmr_clk = 1'b0, rst_n = 1'b0;
   logic       reg_we = 1'b0, glob_ie = 1'b0, flash_busy = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       cpu_stall, rdy_irq;
   int         checks = 0, errors = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;
   always #8 tmr_clk = ~tmr_clk;

   nvm_access_ctrl #(.WRITE_TICKS(TICKS)) u0 (
      .clk(clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_ie(glob_ie),
      .flash_busy(flash_busy), .cpu_stall(cpu_stall), .rdy_irq(rdy_irq));

   // {sel, write value, expected read-back}
   localparam logic [17:0] VEC [7] = '{
      {2'd0, 8'h5A, 8'h5A}, {2'd1, 8'hFF, 8'h0F}, {2'd1, 8'h03, 8'h03},
      {2'd2, 8'hC3, 8'hC3}, {2'd3, 8'h08, 8'h08}, {2'd3, 8'hF0, 8'h00},
      {2'd3, 8'h00, 8'h00}};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // called at a falling edge; takes effect at the next rising edge; returns at the falling edge after it
   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      reg_sel = s; #0.1; d = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_addr(input logic [11:0] a);
      wr(2'd0, a[7:0]); wr(2'd1, {4'h0, a[11:8]});
   endtask

   task automatic read_mem(input logic [11:0] a, output logic [7:0] d);
      set_addr(a); wr(2'd3, 8'h01); idle(4); rd(2'd2, d);
   endtask

   task automatic wait_done(input string req);
      logic [7:0] v;
      int n = 0;
      rd(2'd3, v);
      while (v[1] && n < 600) begin @(negedge clk); n++; rd(2'd3, v); end
      chk(req, {7'd0, v[1]}, 8'h00);
   endtask

   initial begin
      logic [7:0] v;
      idle(3); rst_n = 1'b1; glob_ie = 1'b1;
      // R1 reset state
      rd(2'd3, v); chk("R1 ctrl", v, 8'h00);
      rd(2'd2, v); chk("R1 data", v, 8'h00);
      chk("R1 stall", {7'd0, cpu_stall}, 8'h00);
      chk("R1 irq", {7'd0, rdy_irq}, 8'h00);

      // R2/R3 register table
      for (int i = 0; i < 7; i++) begin
         wr(VEC[i][17:16], VEC[i][15:8]);
         rd(VEC[i][17:16], v);
         chk((VEC[i][17:16] == 2'd3) ? "R3 table" : "R2 table", v, VEC[i][7:0]);
      end

      // R4 arm window
      wr(2'd3, 8'h04);
      for (int i = 0; i < 5; i++) begin
         rd(2'd3, v); chk("R4 arm", {7'd0, v[2]}, (i < 4) ? 8'h01 : 8'h00);
         @(negedge clk);
      end
      wr(2'd3, 8'h00); wr(2'd3, 8'h04); wr(2'd3, 8'h00);
      rd(2'd3, v); chk("R4 no sw clear", {7'd0, v[2]}, 8'h01);
      idle(5);

      // R5 write without arm, then accepted write with stall R9
      set_addr(12'h123); wr(2'd2, 8'hA5);
      wr(2'd3, 8'h02); rd(2'd3, v); chk("R5 no arm", {7'd0, v[1]}, 8'h00);
      wr(2'd3, 8'h04); wr(2'd3, 8'h02);
      chk("R9 stall c1", {7'd0, cpu_stall}, 8'h01);
      rd(2'd3, v); chk("R5 busy", {7'd0, v[1]}, 8'h01);
      @(negedge clk); chk("R9 stall c2", {7'd0, cpu_stall}, 8'h01);
      @(negedge clk); chk("R9 stall end", {7'd0, cpu_stall}, 8'h00);
      // R10 ignored during write
      wr(2'd0, 8'h77); rd(2'd0, v); chk("R10 addr", v, 8'h23);
      wr(2'd2, 8'h11); wr(2'd3, 8'h01);
      chk("R10 no stall", {7'd0, cpu_stall}, 8'h00);
      rd(2'd2, v); chk("R10 data", v, 8'h11);
      wr(2'd3, 8'h00); rd(2'd3, v); chk("R7 sw no clear", {7'd0, v[1]}, 8'h01);
      idle(140); rd(2'd3, v); chk("R7 min time", {7'd0, v[1]}, 8'h01);
      wait_done("R7 clears");
      // R8 read with stall
      set_addr(12'h123); wr(2'd3, 8'h01);
      rd(2'd2, v); chk("R8 data", v, 8'hA5);
      for (int i = 0; i < 5; i++) begin
         chk("R8 stall", {7'd0, cpu_stall}, (i < 4) ? 8'h01 : 8'h00);
         @(negedge clk);
      end

      // R4 boundary: write on last armed cycle accepted
      set_addr(12'h0F0); wr(2'd2, 8'h3C);
      wr(2'd3, 8'h04); idle(3); wr(2'd3, 8'h02);
      rd(2'd3, v); chk("R4 last cycle", {7'd0, v[1]}, 8'h01);
      wait_done("R7 clears 2");
      read_mem(12'h0F0, v); chk("R4 last cycle mem", v, 8'h3C);
      // one cycle late: rejected
      wr(2'd2, 8'hC7);
      wr(2'd3, 8'h04); idle(4); wr(2'd3, 8'h02);
      rd(2'd3, v); chk("R4 late", {7'd0, v[1]}, 8'h00);
      read_mem(12'h0F0, v); chk("R5 late mem", v, 8'h3C);

      // R6 flash busy blocks
      wr(2'd2, 8'h99); flash_busy = 1'b1;
      wr(2'd3, 8'h04); wr(2'd3, 8'h02);
      rd(2'd3, v); chk("R6 blocked", {7'd0, v[1]}, 8'h00);
      flash_busy = 1'b0;
      read_mem(12'h0F0, v); chk("R6 mem", v, 8'h3C);

      // R11 interrupt level
      wr(2'd3, 8'h08); chk("R11 idle", {7'd0, rdy_irq}, 8'h01);
      glob_ie = 1'b0; #0.1; chk("R11 gated", {7'd0, rdy_irq}, 8'h00);
      glob_ie = 1'b1;
      wr(2'd3, 8'h0C); wr(2'd3, 8'h0A);
      chk("R11 busy", {7'd0, rdy_irq}, 8'h00);
      wait_done("R7 clears 3");
      chk("R11 after", {7'd0, rdy_irq}, 8'h01);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule